// File: doc/BRIEF.md
# Collision-Aware Shared-Bus Serial Transmitter

This block turns parallel bytes into asynchronous serial frames on a single wired-AND line that several stations share. A byte enters through a valid/ready handshake. The block then watches the line until it has been quiet long enough. It waits a further pseudo-random number of bit times and starts only if the line is still quiet. A logic 0 is sent by pulling the line low. A logic 1 is sent by releasing the line and letting the external pull-up lift it.

While a frame is going out, the level read back from the line is compared with the level being driven at the middle tick of every bit. If the two differ, another station has won arbitration with a dominant 0. The block releases the line on the next clock, raises a one-clock collision pulse and keeps the byte. It then repeats the whole access sequence until the frame goes through. A station that drives 0 while others also pull low sees no mismatch and finishes its frame. A line-busy flag is also output.

Top module: `shared_bus_tx`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1, `bus_pull_low`, `tx_active`, `collision` and `tx_done` are 0, and `bus_busy` is 1.
- R2: A byte is accepted on a clock where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until that byte's frame has completed.
- R3: A frame lasts 10 bit times of TICKS_PER_BIT (default 8) clocks each. The bits are a start bit 0, then the 8 data bits least-significant first, then a stop bit 1. A 0 is driven as `bus_pull_low`=1 and a 1 as `bus_pull_low`=0. The line is never pulled outside a frame.
- R4: `line_in` passes through a 2-flop synchronizer. `bus_busy` is 0 only after the synchronized line has been high for IDLE_BITS*TICKS_PER_BIT (default 80) consecutive clocks. Any low sample sets it back to 1. With the line high out of reset, `bus_busy` falls after exactly 80 clocks.
- R5: A frame never starts while `bus_busy` is 1. Its first clock comes at least 80 clocks after the line was last low.
- R6: Once the line is quiet, the start is delayed by a further 0 to 15 whole bit times. The count is drawn for each attempt from an 8-bit LFSR that steps every clock. A low on the line during this delay sends the block back to waiting for a quiet line.
- R7: At the middle tick (tick 4 of 0..7) of each bit, a mismatch between the driven and synchronized levels ends the frame. On the next clock the line is released, `tx_active` is 0 and `collision` is 1 for exactly one clock.
- R8: After a collision the byte is kept and `in_ready` stays 0. The byte is sent again in full after a new quiet period and a new random delay.
- R9: Driving a 0 while another station also pulls low is not a collision, and the frame continues unchanged.
- R10: `tx_done` is a one-clock pulse on the clock after the stop bit's last tick. `in_ready` returns to 1 on that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-tick clock (TICKS_PER_BIT clocks per bit) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| line_in | input | 1 | Level read from the shared line (asynchronous) |
| bus_pull_low | output | 1 | 1 = drive the shared line low, 0 = release it |
| bus_busy | output | 1 | Line not yet quiet for the idle period |
| tx_active | output | 1 | A frame is being driven |
| collision | output | 1 | One-clock pulse: arbitration lost, frame aborted |
| tx_done | output | 1 | One-clock pulse: frame finished |

## Verification
The bench models the shared line as the wired-AND of the block's pull and a second station's pull. It goes after the exact clock of the abort and the pulse width there: a design that compared at the wrong tick, or that kept driving after a mismatch, would show the pulse late or still pull the line. It checks that a lost byte is resent intact, and that a late or missing retry is reported. It also checks that a station sending 0 under another station's 0 is left alone; a design that tested for any low line would abort there by mistake. Start times are checked against the quiet period and the largest possible delay, so a design that started early, or ignored the carrier, is caught.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  localparam int unsigned LFSR_W = 8;

  typedef enum logic [1:0] {
    ST_EMPTY   = 2'd0,
    ST_SENSE   = 2'd1,
    ST_BACKOFF = 2'd2,
    ST_SEND    = 2'd3
  } tx_state_e;

  // one Galois step, taps for x^8 + x^6 + x^5 + x^4 + 1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ 8'hB8;
    return n;
  endfunction

  // a span of bit times expressed in clocks
  function automatic int unsigned bits_to_clocks(input int unsigned bits,
                                                 input int unsigned ticks);
    return bits * ticks;
  endfunction

endpackage

// File: rtl/line_sense.sv
module line_sense #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_CYC    = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_lvl,
  output logic bus_idle
);
  localparam int unsigned QW = $clog2(IDLE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [QW-1:0]          quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  assign line_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)                        quiet_q <= '0;
    else if (!line_lvl)                quiet_q <= '0;
    else if (quiet_q != QW'(IDLE_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  assign bus_idle = (quiet_q == QW'(IDLE_CYC));

endmodule

// File: rtl/backoff_gen.sv
module backoff_gen
  import sbt_pkg::*;
#(
  parameter logic [7:0]  SEED    = 8'h5D,
  parameter int unsigned DELAY_W = 4,
  parameter int unsigned TICKS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = DELAY_W + $clog2(TICKS) + 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_step(lfsr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (arm)
      cnt_q <= CW'(lfsr_q[DELAY_W-1:0]) * CW'(TICKS);
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TICKS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  input  logic              line_lvl,
  output logic              cur_bit,
  output logic              mid_mismatch,
  output logic              frame_end
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned TW      = $clog2(TICKS);
  localparam int unsigned IW      = $clog2(FRAME_W);
  localparam int unsigned MID     = TICKS / 2;

  logic [FRAME_W-1:0] sh_q;
  logic [TW-1:0]      tick_q;
  logic [IW-1:0]      idx_q;
  logic               last_tick;
  logic               mid_tick;

  assign last_tick = (tick_q == TW'(TICKS - 1));
  assign mid_tick  = (tick_q == TW'(MID));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      tick_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      sh_q   <= {1'b1, data, 1'b0};
      tick_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      if (last_tick) begin
        tick_q <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        idx_q  <= idx_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign cur_bit      = sh_q[0];
  assign mid_mismatch = en && mid_tick && (sh_q[0] != line_lvl);
  assign frame_end    = en && last_tick && (idx_q == IW'(FRAME_W - 1));

endmodule

// File: rtl/shared_bus_tx.sv
module shared_bus_tx
  import sbt_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 8,
  parameter int unsigned IDLE_BITS     = 10,
  parameter int unsigned DELAY_W       = 4,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter logic [7:0]  LFSR_SEED     = 8'h5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              line_in,
  output logic              bus_pull_low,
  output logic              bus_busy,
  output logic              tx_active,
  output logic              collision,
  output logic              tx_done
);
  localparam int unsigned IDLE_CYC = bits_to_clocks(IDLE_BITS, TICKS_PER_BIT);

  tx_state_e         state_q;
  logic [DATA_W-1:0] hold_q;
  logic              coll_q;
  logic              done_q;

  logic line_lvl;
  logic bus_idle;
  logic delay_arm;
  logic delay_run;
  logic delay_expired;
  logic frame_load;
  logic cur_bit;
  logic mid_mismatch;
  logic frame_end;

  line_sense #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDLE_CYC   (IDLE_CYC)
  ) u_sense (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .line_lvl(line_lvl),
    .bus_idle(bus_idle)
  );

  backoff_gen #(
    .SEED   (LFSR_SEED),
    .DELAY_W(DELAY_W),
    .TICKS  (TICKS_PER_BIT)
  ) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (delay_arm),
    .run    (delay_run),
    .expired(delay_expired)
  );

  frame_shifter #(
    .DATA_W(DATA_W),
    .TICKS (TICKS_PER_BIT)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (frame_load),
    .en          (tx_active),
    .data        (hold_q),
    .line_lvl    (line_lvl),
    .cur_bit     (cur_bit),
    .mid_mismatch(mid_mismatch),
    .frame_end   (frame_end)
  );

  assign delay_arm  = (state_q == ST_SENSE) && bus_idle;
  assign delay_run  = (state_q == ST_BACKOFF);
  assign frame_load = (state_q == ST_BACKOFF) && bus_idle && delay_expired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      hold_q  <= '0;
      coll_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      coll_q <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_EMPTY: begin
          if (in_valid) begin
            hold_q  <= in_data;
            state_q <= ST_SENSE;
          end
        end
        ST_SENSE: begin
          if (bus_idle) state_q <= ST_BACKOFF;
        end
        ST_BACKOFF: begin
          if (!bus_idle)          state_q <= ST_SENSE;
          else if (delay_expired) state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (mid_mismatch) begin
            state_q <= ST_SENSE;
            coll_q  <= 1'b1;
          end else if (frame_end) begin
            state_q <= ST_EMPTY;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_EMPTY;
      endcase
    end
  end

  assign in_ready     = (state_q == ST_EMPTY);
  assign tx_active    = (state_q == ST_SEND);
  assign bus_pull_low = tx_active && !cur_bit;
  assign bus_busy     = !bus_idle;
  assign collision    = coll_q;
  assign tx_done      = done_q;

endmodule

// File: rtl/shared_bus_tx_chk.sv
module shared_bus_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic tx_active,
  input logic bus_pull_low,
  input logic bus_busy,
  input logic collision,
  input logic tx_done,
  input logic mid_mismatch,
  input logic frame_end
);

  AST_READY_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tx_active); // R2

  AST_NO_PULL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !bus_pull_low); // R3

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> bus_pull_low); // R3

  AST_START_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(!bus_busy)); // R5

  AST_ABORT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mid_mismatch |=> (collision && !tx_active && !bus_pull_low)); // R7

  AST_COLL_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> !collision); // R7

  AST_KEEP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> !in_ready); // R8

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (tx_done && in_ready)); // R10

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R10

endmodule

bind shared_bus_tx shared_bus_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .tx_active   (tx_active),
  .bus_pull_low(bus_pull_low),
  .bus_busy    (bus_busy),
  .collision   (collision),
  .tx_done     (tx_done),
  .mid_mismatch(mid_mismatch),
  .frame_end   (frame_end)
);

// File: tb/sim_shared_bus_tx.sv
module sim_shared_bus_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 8;
  localparam int IDLE_CYC   = 80;
  localparam int MAX_DELAY  = 15 * TICKS;
  localparam int NVEC       = 6;
  // {byte, expected line pattern in time order: bit i = i-th bit sent}
  localparam logic [17:0] VECS [NVEC] = '{
    {8'h00, 10'h200}, {8'hFF, 10'h3FE}, {8'hA5, 10'h34A},
    {8'h3C, 10'h278}, {8'h81, 10'h302}, {8'h5A, 10'h2B4}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       other_pull = 1'b0;
  logic       in_ready, bus_pull_low, bus_busy, tx_active, collision, tx_done;
  wire        line_in = ~(bus_pull_low | other_pull);

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int hi_run = 0;

  shared_bus_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .line_in(line_in), .bus_pull_low(bus_pull_low),
    .bus_busy(bus_busy), .tx_active(tx_active), .collision(collision),
    .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    hi_run <= line_in ? hi_run + 1 : 0;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: run hung actual=%0d expected<=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic submit(input logic [7:0] d, output int quiet_acc);
    while (!in_ready) @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    quiet_acc = hi_run;
  endtask

  task automatic wait_start(input int limit, output int waited, output int quiet_seen);
    waited = 0;
    while (!bus_pull_low && waited < limit) begin
      @(negedge clk);
      waited++;
    end
    quiet_seen = hi_run;
  endtask

  // called on the first clock of the start bit (n = 0); ends at n = 80
  task automatic run_frame(input int pfrom, input int pto,
                           output logic [9:0] pat, output bit coll);
    pat  = '0;
    coll = 1'b0;
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      other_pull = (n >= pfrom && n < pto);
      if (collision) coll = 1'b1;
      if (n % 8 == 4) pat[n/8] = ~bus_pull_low;
    end
    other_pull = 1'b0;
  endtask

  initial begin
    int qacc, w, q, first_q, spread;
    logic [9:0] pat;
    bit coll, pulled;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    chk(bus_pull_low == 1'b0 && tx_active == 1'b0, "R1 line released in reset", bus_pull_low, 0);
    chk(collision == 1'b0 && tx_done == 1'b0, "R1 pulses low in reset", collision, 0);
    chk(bus_busy == 1'b1, "R1 busy in reset", bus_busy, 1);
    rst_n = 1'b1;

    // R4 busy falls after exactly 80 quiet clocks
    repeat (79) @(negedge clk);
    chk(bus_busy == 1'b1, "R4 busy before 80 clocks", bus_busy, 1);
    @(negedge clk);
    chk(bus_busy == 1'b0, "R4 idle at 80 clocks", bus_busy, 0);

    // table walk: R2 R3 R5 R6 R10
    spread  = 0;
    first_q = -1;
    for (int i = 0; i < NVEC; i++) begin
      submit(VECS[i][17:10], qacc);
      chk(in_ready == 1'b0, "R2 ready drops after accept", in_ready, 0);
      wait_start(2000, w, q);
      chk(bus_pull_low == 1'b1, "R3 frame start seen", bus_pull_low, 1);
      chk(q >= IDLE_CYC, "R5 start after quiet period", q, IDLE_CYC);
      chk(w <= ((qacc >= IDLE_CYC) ? 0 : IDLE_CYC + 4 - qacc) + MAX_DELAY + 8,
          "R6 start within delay bound", w, MAX_DELAY);
      if (first_q < 0) first_q = q;
      else if (q != first_q) spread = spread + 1;
      run_frame(-1, -1, pat, coll);
      chk(pat == VECS[i][9:0], "R3 frame bits", pat, VECS[i][9:0]);
      chk(!coll, "R7 no collision on clean line", coll, 0);
      chk(tx_done == 1'b1 && in_ready == 1'b1, "R10 done with ready", tx_done, 1);
      @(negedge clk);
      chk(tx_done == 1'b0, "R10 done one clock", tx_done, 0);
    end
    chk(spread > 0, "R6 delay varies between attempts", spread, 1);

    // R4 a single low clock marks the line busy again
    repeat (100) @(negedge clk);
    other_pull = 1'b1;
    @(negedge clk);
    other_pull = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_busy == 1'b1, "R4 busy after low pulse", bus_busy, 1);
    repeat (100) @(negedge clk);
    chk(bus_busy == 1'b0, "R4 idle again after quiet", bus_busy, 0);

    // R5 carrier held by another station: no start
    other_pull = 1'b1;
    submit(8'hC3, qacc);
    pulled = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (bus_pull_low) pulled = 1'b1;
    end
    chk(!pulled, "R5 no start while line busy", pulled, 0);
    chk(bus_busy == 1'b1, "R4 busy while held low", bus_busy, 1);
    other_pull = 1'b0;
    wait_start(2000, w, q);
    chk(q >= IDLE_CYC, "R5 start after release and quiet", q, IDLE_CYC);
    run_frame(-1, -1, pat, coll);
    chk(pat == 10'h386, "R3 frame after deferral", pat, 10'h386);

    // R7 R8 collision on the first data bit (a 1) of 0xFF
    submit(8'hFF, qacc);
    wait_start(2000, w, q);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (n == 8) other_pull = 1'b1;
    end
    chk(collision == 1'b0, "R7 no pulse before mid tick", collision, 0);
    @(negedge clk); // n = 13
    chk(collision == 1'b1, "R7 collision pulse", collision, 1);
    chk(bus_pull_low == 1'b0 && tx_active == 1'b0, "R7 line released on abort", bus_pull_low, 0);
    other_pull = 1'b0;
    @(negedge clk); // n = 14
    chk(collision == 1'b0, "R7 collision one clock", collision, 0);
    chk(in_ready == 1'b0, "R8 byte kept after collision", in_ready, 0);
    wait_start(3000, w, q);
    chk(bus_pull_low == 1'b1, "R8 retry started", bus_pull_low, 1);
    chk(q >= IDLE_CYC, "R8 retry after quiet", q, IDLE_CYC);
    run_frame(-1, -1, pat, coll);
    chk(pat == 10'h3FE, "R8 retried frame intact", pat, 10'h3FE);
    chk(tx_done == 1'b1, "R10 done after retry", tx_done, 1);

    // R9 another station pulls low while this one drives 0
    submit(8'h00, qacc);
    wait_start(2000, w, q);
    run_frame(8, 24, pat, coll);
    chk(!coll, "R9 no collision when both drive 0", coll, 0);
    chk(pat == 10'h200, "R9 frame unchanged", pat, 10'h200);
    chk(tx_done == 1'b1, "R9 frame completed", tx_done, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule